// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit decides where a 32-bit integer core fetches next. It holds the program counter in a register and, from the instruction now being retired and its two source operand values, works out combinationally the following PC, the return address for a link register, whether control flow was redirected, and whether the redirected target breaks 4-byte alignment. It rebuilds the bit-scattered branch and jump offsets, performs the six conditional comparisons in signed and unsigned forms, and handles both the PC-relative jump and the register-indirect jump.

Instructions enter as a stream qualified by `in_valid`. The unit accepts every instruction in the cycle it is presented and never asserts back-pressure, so no ready signal exists; a producer may present a new instruction every cycle. An instruction is consumed on the rising clock edge where `in_valid` is high. The outputs are valid in the same cycle as the inputs and depend only on the current PC and the presented operands.

Top module: `pc_steer`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `pc_o` equals the parameter `RESET_PC` (default 0x0000_1000).
- R2: For any opcode (instr[6:0]) other than 1100011, 1101111 and 1100111, `next_pc` is `pc_o`+4, `taken` is 0, and `link_val` is `pc_o`+4 for every instruction.
- R3: Opcode 1101111 gives `taken`=1 and `next_pc` = `pc_o` + sign-extended offset, where offset[20]=instr[31], offset[10:1]=instr[30:21], offset[11]=instr[20], offset[19:12]=instr[19:12], offset[0]=0.
- R4: Opcode 1100111 gives `taken`=1 and `next_pc` = (`rs1_val` + sign-extended instr[31:20]) with bit 0 cleared.
- R5: Opcode 1100011 with funct3 (instr[14:12]) 000 is taken when the operands are equal; with 001 when they differ. A taken branch goes to `pc_o` + sign-extended offset with offset[12]=instr[31], offset[11]=instr[7], offset[10:5]=instr[30:25], offset[4:1]=instr[11:8], offset[0]=0.
- R6: funct3 100 is taken when `rs1_val` < `rs2_val` as signed numbers; 101 when `rs1_val` >= `rs2_val` signed.
- R7: funct3 110 is taken when `rs1_val` < `rs2_val` unsigned; 111 when `rs1_val` >= `rs2_val` unsigned.
- R8: A branch with funct3 010 or 011 is never taken and yields `next_pc` = `pc_o`+4.
- R9: A branch whose comparison fails gives `taken`=0 and `next_pc` = `pc_o`+4.
- R10: `misaligned` is 1 exactly when `taken` is 1 and `next_pc[1]` is 1; an instruction that raises it leaves `pc_o` unchanged.
- R11: On an edge with `in_valid` high and `misaligned` low, `pc_o` takes the value `next_pc` had; with `in_valid` low `pc_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented and consumed this cycle |
| instr | input | 32 | Raw instruction word |
| rs1_val | input | XLEN | First source operand value |
| rs2_val | input | XLEN | Second source operand value |
| pc_o | output | XLEN | Current program counter |
| next_pc | output | XLEN | Address of the following instruction |
| link_val | output | XLEN | Return address, PC+4 |
| taken | output | 1 | Control flow redirected |
| misaligned | output | 1 | Redirected target not on a 4-byte boundary |

## Verification
A wrong PC register shows at `pc_o` and, through every relative target and the link value, at the very next combinational output, so a single corrupted update is visible within one cycle of the edge that caused it. A misplaced offset bit shows only when the bench places a one in that bit, so the offsets chosen set the high, middle and sign bits of both scattered formats. Swapped signed and unsigned comparisons only differ when an operand has its top bit set, so the comparison scenarios pair a negative value against a small positive one.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int ILEN = 32;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [2:0] F3_EQ  = 3'b000;
  localparam logic [2:0] F3_NE  = 3'b001;
  localparam logic [2:0] F3_LT  = 3'b100;
  localparam logic [2:0] F3_GE  = 3'b101;
  localparam logic [2:0] F3_LTU = 3'b110;
  localparam logic [2:0] F3_GEU = 3'b111;
endpackage

// File: rtl/pcs_imm.sv
module pcs_imm #(
  parameter int XLEN = 32
) (
  input  logic [31:7]     ibits,
  output logic [XLEN-1:0] i_imm,
  output logic [XLEN-1:0] b_imm,
  output logic [XLEN-1:0] j_imm
);
  logic s;
  assign s = ibits[31];

  // register-indirect jump: plain 12-bit field at the top
  assign i_imm = {{(XLEN-12){s}}, ibits[31:20]};
  // conditional branch: 13-bit even offset, bits gathered from four places
  assign b_imm = {{(XLEN-13){s}}, s, ibits[7], ibits[30:25], ibits[11:8], 1'b0};
  // relative jump: 21-bit even offset
  assign j_imm = {{(XLEN-21){s}}, s, ibits[19:12], ibits[20], ibits[30:21], 1'b0};
endmodule

// File: rtl/pcs_cmp.sv
module pcs_cmp
  import pcs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [2:0]      f3,
  output logic            hit
);
  logic eq, lts, ltu;
  assign eq  = (opa == opb);
  assign lts = ($signed(opa) < $signed(opb));
  assign ltu = (opa < opb);

  always_comb begin
    unique case (f3)
      F3_EQ:   hit = eq;
      F3_NE:   hit = !eq;
      F3_LT:   hit = lts;
      F3_GE:   hit = !lts;
      F3_LTU:  hit = ltu;
      F3_GEU:  hit = !ltu;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pc_steer.sv
module pc_steer
  import pcs_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] link_val,
  output logic            taken,
  output logic            misaligned
);
  localparam logic [XLEN-1:0] STEP = XLEN'(ILEN / 8);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] i_imm, b_imm, j_imm;
  logic [XLEN-1:0] seq_pc, br_tgt, jal_tgt, jalr_sum;
  logic [6:0]      opc;
  logic            is_br, is_jal, is_jalr, cmp_hit;

  assign opc     = instr[6:0];
  assign is_br   = (opc == OPC_BRANCH);
  assign is_jal  = (opc == OPC_JAL);
  assign is_jalr = (opc == OPC_JALR);

  pcs_imm #(.XLEN(XLEN)) u_imm (
    .ibits (instr[31:7]),
    .i_imm (i_imm),
    .b_imm (b_imm),
    .j_imm (j_imm)
  );

  pcs_cmp #(.XLEN(XLEN)) u_cmp (
    .opa (rs1_val),
    .opb (rs2_val),
    .f3  (instr[14:12]),
    .hit (cmp_hit)
  );

  assign seq_pc   = pc_q + STEP;
  assign br_tgt   = pc_q + b_imm;
  assign jal_tgt  = pc_q + j_imm;
  assign jalr_sum = rs1_val + i_imm;

  always_comb begin
    taken   = 1'b0;
    next_pc = seq_pc;
    if (is_jal) begin
      taken   = 1'b1;
      next_pc = jal_tgt;
    end else if (is_jalr) begin
      taken   = 1'b1;
      next_pc = {jalr_sum[XLEN-1:1], 1'b0};
    end else if (is_br && cmp_hit) begin
      taken   = 1'b1;
      next_pc = br_tgt;
    end
  end

  assign link_val   = seq_pc;
  assign misaligned = taken && next_pc[1];

  always_ff @(posedge clk) begin
    if (!rst_n)                      pc_q <= RESET_PC;
    else if (in_valid && !misaligned) pc_q <= next_pc;
  end

  assign pc_o = pc_q;

  // R1: reset value is visible at the next edge
  p_reset_pc_r1: assert property (@(posedge clk) !rst_n |=> pc_o == RESET_PC);
  // R11: accepted, aligned instruction commits its target
  p_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !misaligned |=> pc_o == $past(next_pc));
  // R11: no instruction, no movement
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pc_o));
  // R10: a bad target never reaches the register
  p_mis_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |=> $stable(pc_o));
  // R10: flag only on redirected flow
  p_mis_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> taken);
  // R4: indirect target always even
  p_jalr_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_jalr |-> !next_pc[0]);
  // R8: reserved comparison codes never redirect
  p_bad_f3_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_br && instr[14:13] == 2'b01 |-> !taken && next_pc == link_val);
endmodule

// File: tb/pc_steer_tb.sv
module pc_steer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_ADDR = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [31:0] rs1_val = 32'h0;
  logic [31:0] rs2_val = 32'h0;
  logic [31:0] pc_o, next_pc, link_val;
  logic        taken, misaligned;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mpc;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_steer #(.XLEN(32), .RESET_PC(RST_ADDR)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .pc_o(pc_o), .next_pc(next_pc),
    .link_val(link_val), .taken(taken), .misaligned(misaligned)
  );

  function automatic logic [31:0] enc_b(input logic [12:0] o, input logic [2:0] f3);
    return {o[12], o[10:5], 5'd2, 5'd1, f3, o[4:1], o[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(input logic [20:0] o);
    return {o[20], o[10:1], o[11], o[19:12], 5'd1, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_jr(input logic [11:0] imm);
    return {imm, 5'd3, 3'b000, 5'd1, 7'b1100111};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // drive one instruction, check outputs, let one edge pass, update model
  task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                      input logic v, input logic [31:0] exp_next, input logic exp_tk,
                      input string tag);
    logic exp_mis;
    @(negedge clk);
    instr = ins; rs1_val = a; rs2_val = b; in_valid = v;
    #1;
    exp_mis = exp_tk && exp_next[1];
    chk({tag, " pc"}, pc_o, mpc);
    chk({tag, " next"}, next_pc, exp_next);
    chk({tag, " taken"}, {31'd0, taken}, {31'd0, exp_tk});
    chk({tag, " link"}, link_val, mpc + 32'd4);
    chk({tag, " mis"}, {31'd0, misaligned}, {31'd0, exp_mis});
    @(posedge clk);
    if (v && !exp_mis) mpc = exp_next;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " pc after"}, pc_o, mpc);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset pc", pc_o, RST_ADDR);
    rst_n = 1'b1;
    mpc = RST_ADDR;
    @(negedge clk);
    chk("R1 pc after release", pc_o, RST_ADDR);
  endtask

  task automatic t_plain();
    step(32'h002081b3, 32'h5, 32'h7, 1'b1, mpc + 4, 1'b0, "R2 alu op");
    step(32'h000010b7, 32'h0, 32'h0, 1'b1, mpc + 4, 1'b0, "R2 upper-imm op");
  endtask

  task automatic t_jal();
    step(enc_j(21'h00800), 0, 0, 1'b1, mpc + 32'h800, 1'b1, "R3 jal bit11");
    step(enc_j(21'h7F404), 0, 0, 1'b1, mpc + 32'h7F404, 1'b1, "R3 jal high bits");
    step(enc_j(-21'sd23196), 0, 0, 1'b1, mpc - 32'd23196, 1'b1, "R3 jal backward");
  endtask

  task automatic t_jalr();
    step(enc_jr(12'h7FF), 32'h0000_2001, 0, 1'b1, 32'h0000_2800, 1'b1, "R4 jalr sum");
    step(enc_jr(12'hFFC), 32'h0000_3005, 0, 1'b1, 32'h0000_3000, 1'b1, "R4 jalr clear bit0");
  endtask

  task automatic t_eq();
    step(enc_b(13'd16, 3'b000), 32'h55, 32'h55, 1'b1, mpc + 16, 1'b1, "R5 beq equal");
    step(enc_b(13'd16, 3'b001), 32'h55, 32'h55, 1'b1, mpc + 4, 1'b0, "R5 bne equal");
    step(enc_b(13'd16, 3'b000), 32'h55, 32'h56, 1'b1, mpc + 4, 1'b0, "R9 beq unequal");
    step(enc_b(-13'sd8, 3'b001), 32'h55, 32'h56, 1'b1, mpc - 8, 1'b1, "R5 bne backward");
    step(enc_b(13'h1000, 3'b000), 0, 0, 1'b1, mpc - 32'h1000, 1'b1, "R5 branch max negative");
    step(enc_b(13'h0800, 3'b000), 0, 0, 1'b1, mpc + 32'h800, 1'b1, "R5 branch bit11");
  endtask

  task automatic t_signed();
    step(enc_b(13'd32, 3'b100), 32'hFFFF_FFFF, 32'd1, 1'b1, mpc + 32, 1'b1, "R6 blt neg<pos");
    step(enc_b(13'd32, 3'b101), 32'hFFFF_FFFF, 32'd1, 1'b1, mpc + 4, 1'b0, "R6 bge neg>=pos");
    step(enc_b(13'd32, 3'b100), 32'd9, 32'd9, 1'b1, mpc + 4, 1'b0, "R6 blt equal");
    step(enc_b(13'd32, 3'b101), 32'd9, 32'd9, 1'b1, mpc + 32, 1'b1, "R6 bge equal");
  endtask

  task automatic t_unsigned();
    step(enc_b(13'd40, 3'b110), 32'hFFFF_FFFF, 32'd1, 1'b1, mpc + 4, 1'b0, "R7 bltu big<small");
    step(enc_b(13'd40, 3'b111), 32'hFFFF_FFFF, 32'd1, 1'b1, mpc + 40, 1'b1, "R7 bgeu big>=small");
    step(enc_b(13'd40, 3'b110), 32'd3, 32'h8000_0000, 1'b1, mpc + 40, 1'b1, "R7 bltu small<big");
  endtask

  task automatic t_bad_f3();
    step(enc_b(13'd16, 3'b010), 32'd1, 32'd1, 1'b1, mpc + 4, 1'b0, "R8 funct3 010");
    step(enc_b(13'd16, 3'b011), 32'd1, 32'd2, 1'b1, mpc + 4, 1'b0, "R8 funct3 011");
  endtask

  task automatic t_misaligned();
    step(enc_b(13'd6, 3'b000), 32'd4, 32'd4, 1'b1, mpc + 6, 1'b1, "R10 branch target +6");
    step(enc_jr(12'h000), 32'h0000_4002, 0, 1'b1, 32'h0000_4002, 1'b1, "R10 jalr target bit1");
    step(enc_b(13'd6, 3'b001), 32'd4, 32'd4, 1'b1, mpc + 4, 1'b0, "R10 untaken no flag");
  endtask

  task automatic t_idle();
    step(enc_j(21'h00100), 0, 0, 1'b0, mpc + 32'h100, 1'b1, "R11 idle jal");
    step(32'h00000013, 0, 0, 1'b0, mpc + 4, 1'b0, "R11 idle plain");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    mpc = RST_ADDR;
    t_reset();
    t_plain();
    t_jal();
    t_jalr();
    t_eq();
    t_signed();
    t_unsigned();
    t_bad_f3();
    t_misaligned();
    t_idle();
    t_reset();
    summary();
  end
endmodule